// File: doc/BRIEF.md
# Real-Time Clock Calendar Update Engine

This block keeps the wall-clock time and calendar of a real-time clock: seconds, minutes, hours, day of week, day of month, month, year and century, each in a byte register. A one-pulse-per-second tick comes from an external divider. Each accepted tick opens a short update window. At the end of that window the whole time advances by one second, and carries ripple upward as far as the century. The carries respect month lengths and leap years.

Software programs the registers through a plain byte read/write port. A control register sets three things: binary or BCD encoding, 12-hour or 24-hour format, and a freeze bit that stops updates so a new time can be loaded safely. During the update window the time registers are closed to the host. Reads return zero and writes are dropped. The busy status stays readable at all times.

Top module: `rtc_update_engine`

## Requirements
- R1: After reset the registers read seconds 0x00, minutes 0x00, hours 0x00, day of week 0x01, day of month 0x01, month 0x01, year 0x00, century 0x20 and control 0x04. The status register reads 0x00.
- R2: Seconds and minutes count 0 to 59 and then return to 0, carrying into the next field. The top value is 0x59 in BCD and 0x3B in binary.
- R3: With control bit 2 set (24-hour format), hours count 0 to 23 (top value 0x23 BCD, 0x17 binary). Wrapping to 00 advances the day.
- R4: With control bit 2 clear (12-hour format), hours hold 1 to 12 in bits 6:0 and bit 7 set means PM. 11:59:59 AM becomes 12 PM. 11:59:59 PM becomes 12 AM (bit 7 clear) and advances the day. 12 becomes 01 with the meridiem unchanged.
- R5: When the day advances past the length of the current month (30 for April, June, September and November, 31 for the other non-February months), the day of month returns to 01 and the month advances. Month 12 wraps to 01 and advances the year.
- R6: February has 29 days when the year is divisible by 4, except that year 00 counts as a leap year only if the century is divisible by 4. Otherwise February has 28 days.
- R7: Year 99 wraps to 00 and advances the century. Century 99 wraps to 00.
- R8: Day of week advances by one with each day advance and wraps from 07 to 01.
- R9: A tick is accepted only when the divider-enable input is high, control bit 0 (freeze) is clear and no window is open. Status bit 0 is then high for BUSY_CYC cycles, starting the cycle after the tick. The time registers take their new values at the edge where the status bit falls.
- R10: While the freeze bit is set, ticks are ignored and the time does not change. Writing freeze = 1 while a window is open ends the window at once, and no increment takes place.
- R11: While status bit 0 is high, reads of addresses 0 to 7 return 0x00 and writes to them are dropped.
- R12: Addresses 0 to 7 hold seconds, minutes, hours, day of week, day of month, month, year and century. Address 8 is control, with bit 0 freeze, bit 1 binary (1) or BCD (0), and bit 2 24-hour. Address 9 is status. Writes outside the window load the written byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse once per second from the divider |
| div_en_i | input | 1 | Divider running; ticks are ignored when low |
| we_i | input | 1 | Host write strobe |
| addr_i | input | 4 | Host register address |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data, combinational on addr_i |

## Verification
Randomly chosen valid times, biased toward 59 seconds, 59 minutes, the last hour and month ends, are run in all four mixes of encoding and hour format. This separates faults in single carries from faults in the decimal/binary conversion. Directed cases check carries that only one date exposes: the three century-rule leap decisions, 30-day versus 31-day months, both meridiem transitions and the full cascade from year 99 of century 99. Timing patterns place a host write, a read and a freeze write inside the open window, and send a tick while the divider is off. These show whether the window blocks the host, whether an abort suppresses the increment and whether a tick is gated correctly.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   localparam int unsigned NTIME = 8;

   localparam logic [3:0] A_CTRL = 4'd8;
   localparam logic [3:0] A_STAT = 4'd9;

   typedef struct packed {
      logic h24;
      logic binary;
      logic freeze;
   } ctrl_t;

   function automatic logic [7:0] bcd2bin(input logic [7:0] v);
      return ({4'd0, v[7:4]} * 8'd10) + {4'd0, v[3:0]};
   endfunction

   function automatic logic [7:0] bin2bcd(input logic [7:0] v);
      logic [7:0] t;
      logic [7:0] o;
      t = v / 8'd10;
      o = v % 8'd10;
      return (t << 4) | o;
   endfunction

   // lowest legal value of field i (binary)
   function automatic logic [7:0] field_lo(input int i);
      return (i == 3 || i == 4 || i == 5) ? 8'd1 : 8'd0;
   endfunction

   // highest legal value of field i (binary); day of month is dynamic
   function automatic logic [7:0] field_hi(input int i);
      case (i)
         0, 1:    return 8'd59;
         3:       return 8'd7;
         5:       return 8'd12;
         default: return 8'd99;
      endcase
   endfunction

   function automatic logic is_leap(input logic [7:0] yr, input logic [7:0] cen);
      return (yr[1:0] == 2'd0) && ((yr != 8'd0) || (cen[1:0] == 2'd0));
   endfunction

   function automatic logic [7:0] month_days(input logic [7:0] mon, input logic leap);
      case (mon)
         8'd2:                    return leap ? 8'd29 : 8'd28;
         8'd4, 8'd6, 8'd9, 8'd11: return 8'd30;
         default:                 return 8'd31;
      endcase
   endfunction
endpackage

// File: rtl/rtc_wrap_inc.sv
module rtc_wrap_inc import rtc_pkg::*; (
   input  logic [7:0] cur_i,
   input  logic [7:0] lo_i,
   input  logic [7:0] hi_i,
   input  logic       binary_i,
   input  logic       en_i,
   output logic [7:0] nxt_o,
   output logic       wrap_o
);
   logic [7:0] val;
   logic [7:0] nb;

   always_comb begin
      val    = binary_i ? cur_i : bcd2bin(cur_i);
      wrap_o = en_i && (val >= hi_i);
      nb     = wrap_o ? lo_i : val + 8'd1;
      if (!en_i)         nxt_o = cur_i;
      else if (binary_i) nxt_o = nb;
      else               nxt_o = bin2bcd(nb);
   end
endmodule

// File: rtl/rtc_hour_step.sv
module rtc_hour_step import rtc_pkg::*; (
   input  logic [7:0] cur_i,
   input  logic       binary_i,
   input  logic       h24_i,
   input  logic       en_i,
   output logic [7:0] nxt_o,
   output logic       wrap_o
);
   logic [7:0] low7, hv, h_int, n, m, e;
   logic       pm, npm;

   always_comb begin
      pm    = !h24_i && cur_i[7];
      low7  = h24_i ? cur_i : {1'b0, cur_i[6:0]};
      hv    = binary_i ? low7 : bcd2bin(low7);
      // normalise to 0..23
      if (h24_i) h_int = hv;
      else       h_int = ((hv == 8'd12) ? 8'd0 : hv) + (pm ? 8'd12 : 8'd0);
      wrap_o = en_i && (h_int >= 8'd23);
      n      = wrap_o ? 8'd0 : h_int + 8'd1;
      npm    = (n >= 8'd12);
      m      = npm ? n - 8'd12 : n;
      if (m == 8'd0) m = 8'd12;
      e      = h24_i ? n : m;
      if (!binary_i) e = bin2bcd(e);
      if (!en_i)      nxt_o = cur_i;
      else if (h24_i) nxt_o = e;
      else            nxt_o = {npm, e[6:0]};
   end
endmodule

// File: rtl/rtc_busy_timer.sv
module rtc_busy_timer #(
   parameter int unsigned BUSY_CYC = 4,
   localparam int unsigned CNT_W = $clog2(BUSY_CYC + 1)
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   input  logic abort_i,
   output logic busy_o,
   output logic fire_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             cnt_q <= '0;
      else if (abort_i)                        cnt_q <= '0;
      else if (cnt_q == '0 && start_i)         cnt_q <= CNT_W'(BUSY_CYC);
      else if (cnt_q != '0)                    cnt_q <= cnt_q - 1'b1;
   end

   assign busy_o = (cnt_q != '0);
   assign fire_o = (cnt_q == CNT_W'(1)) && !abort_i;
endmodule

// File: rtl/rtc_update_engine.sv
module rtc_update_engine import rtc_pkg::*; #(
   parameter int unsigned BUSY_CYC    = 4,
   parameter logic [7:0]  RST_CENTURY = 8'h20,
   parameter bit          RST_H24     = 1'b1,
   parameter bit          RST_BINARY  = 1'b0
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       tick_i,
   input  logic       div_en_i,
   input  logic       we_i,
   input  logic [3:0] addr_i,
   input  logic [7:0] wdata_i,
   output logic [7:0] rdata_o
);
   generate
      if (BUSY_CYC < 1) begin : g_bad_busy
         $error("BUSY_CYC must be at least 1");
      end
   endgenerate

   ctrl_t            ctrl_q;
   logic [7:0]       time_q [NTIME];
   logic [7:0]       nxt    [NTIME];
   logic [NTIME-1:0] wrap, step_en;
   logic             busy, fire, abort, start, ctrl_wr, time_wr;
   logic [7:0]       mon_b, yr_b, cen_b, dim;
   logic             leap;
   logic             unused_carries;

   assign ctrl_wr = we_i && (addr_i == A_CTRL);
   assign abort   = ctrl_q.freeze || (ctrl_wr && wdata_i[0]);
   assign start   = tick_i && div_en_i && !ctrl_q.freeze;
   assign time_wr = we_i && !busy && !addr_i[3];

   rtc_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_timer (
      .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .abort_i(abort),
      .busy_o(busy), .fire_o(fire)
   );

   // calendar limits
   assign mon_b = ctrl_q.binary ? time_q[5] : bcd2bin(time_q[5]);
   assign yr_b  = ctrl_q.binary ? time_q[6] : bcd2bin(time_q[6]);
   assign cen_b = ctrl_q.binary ? time_q[7] : bcd2bin(time_q[7]);
   assign leap  = is_leap(yr_b, cen_b);
   assign dim   = month_days(mon_b, leap);

   // carry chain
   assign step_en[0] = fire;
   assign step_en[1] = wrap[0];
   assign step_en[2] = wrap[1];
   assign step_en[3] = wrap[2];
   assign step_en[4] = wrap[2];
   assign step_en[5] = wrap[4];
   assign step_en[6] = wrap[5];
   assign step_en[7] = wrap[6];
   assign unused_carries = wrap[3] ^ wrap[7];

   generate
      for (genvar i = 0; i < NTIME; i++) begin : g_field
         if (i == 2) begin : g_hour
            rtc_hour_step u_hour (
               .cur_i(time_q[i]), .binary_i(ctrl_q.binary), .h24_i(ctrl_q.h24),
               .en_i(step_en[i]), .nxt_o(nxt[i]), .wrap_o(wrap[i])
            );
         end else begin : g_plain
            localparam logic [7:0] FLO = field_lo(i);
            localparam logic [7:0] FHI = field_hi(i);
            rtc_wrap_inc u_inc (
               .cur_i(time_q[i]), .lo_i(FLO), .hi_i((i == 4) ? dim : FHI),
               .binary_i(ctrl_q.binary), .en_i(step_en[i]),
               .nxt_o(nxt[i]), .wrap_o(wrap[i])
            );
         end
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         time_q[0] <= 8'h00;
         time_q[1] <= 8'h00;
         time_q[2] <= 8'h00;
         time_q[3] <= 8'h01;
         time_q[4] <= 8'h01;
         time_q[5] <= 8'h01;
         time_q[6] <= 8'h00;
         time_q[7] <= RST_CENTURY;
      end else if (fire) begin
         for (int k = 0; k < NTIME; k++) time_q[k] <= nxt[k];
      end else if (time_wr) begin
         time_q[addr_i[2:0]] <= wdata_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      ctrl_q <= '{h24: RST_H24, binary: RST_BINARY, freeze: 1'b0};
      else if (ctrl_wr) ctrl_q <= wdata_i[2:0];
   end

   always_comb begin
      if (!addr_i[3])            rdata_o = busy ? 8'h00 : time_q[addr_i[2:0]];
      else if (addr_i == A_CTRL) rdata_o = {5'd0, ctrl_q};
      else if (addr_i == A_STAT) rdata_o = {7'd0, busy};
      else                       rdata_o = 8'h00;
   end
endmodule

// File: rtl/rtc_update_engine_chk.sv
module rtc_update_engine_chk #(
   parameter int unsigned BUSY_CYC = 4,
   localparam int unsigned RW = $clog2(BUSY_CYC + 2)
) (
   input logic       clk_i,
   input logic       rst_ni,
   input logic       tick_i,
   input logic       div_en_i,
   input logic       we_i,
   input logic [3:0] addr_i,
   input logic [7:0] rdata_i,
   input logic       busy_i,
   input logic       fire_i,
   input logic       freeze_i,
   input logic [7:0] sec_i
);
   logic [RW-1:0] run_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     run_q <= '0;
      else if (busy_i) run_q <= (run_q == RW'(BUSY_CYC + 1)) ? run_q : run_q + 1'b1;
      else             run_q <= '0;
   end

   // R9: window never longer than BUSY_CYC cycles
   a_r9_window_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_q <= RW'(BUSY_CYC));

   // R9: a window opens only after an accepted tick
   a_r9_open_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(busy_i) |-> $past(tick_i && div_en_i && !freeze_i));

   // R9: the increment lands only inside the window
   a_r9_fire_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire_i |-> busy_i);

   // R10: frozen time stays put unless the host writes it
   a_r10_frozen_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (freeze_i && !(we_i && !addr_i[3])) |=> $stable(sec_i));

   // R11: time reads blanked while busy
   a_r11_read_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_i && !addr_i[3]) |-> (rdata_i == 8'h00));

   // R11: host writes dropped inside the window
   a_r11_write_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_i && !fire_i) |=> $stable(sec_i));
endmodule

bind rtc_update_engine rtc_update_engine_chk #(.BUSY_CYC(BUSY_CYC)) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .div_en_i(div_en_i),
   .we_i(we_i), .addr_i(addr_i), .rdata_i(rdata_o), .busy_i(busy),
   .fire_i(fire), .freeze_i(ctrl_q.freeze), .sec_i(time_q[0])
);

// File: tb/rtc_update_engine_test.sv
module rtc_update_engine_test;
   localparam int BUSY = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       div_en = 1'b1;
   logic       we = 1'b0;
   logic [3:0] addr = 4'd0;
   logic [7:0] wdata = 8'd0;
   logic [7:0] rdata;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   int m_sec, m_min, m_hr, m_dow, m_dom, m_mon, m_yr, m_cen;
   bit m_bin, m_h24;

   always #5 clk = ~clk;

   rtc_update_engine #(.BUSY_CYC(BUSY)) uut (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .div_en_i(div_en),
      .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
   );

   function automatic logic [7:0] enc(int v);
      if (m_bin) return 8'(v);
      return 8'(((v / 10) << 4) | (v % 10));
   endfunction

   function automatic logic [7:0] enc_hr(int h);
      int m;
      if (m_h24) return enc(h);
      m = h % 12;
      if (m == 0) m = 12;
      return enc(m) | ((h >= 12) ? 8'h80 : 8'h00);
   endfunction

   function automatic int mdays(int mon, int yr, int cen);
      bit leap;
      leap = (yr % 4 == 0) && (yr != 0 || cen % 4 == 0);
      if (mon == 2) return leap ? 29 : 28;
      if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
      return 31;
   endfunction

   function automatic logic [7:0] expect_reg(int a);
      case (a)
         0: return enc(m_sec);
         1: return enc(m_min);
         2: return enc_hr(m_hr);
         3: return enc(m_dow);
         4: return enc(m_dom);
         5: return enc(m_mon);
         6: return enc(m_yr);
         default: return enc(m_cen);
      endcase
   endfunction

   task automatic model_step();
      m_sec++;
      if (m_sec == 60) begin
         m_sec = 0; m_min++;
         if (m_min == 60) begin
            m_min = 0; m_hr++;
            if (m_hr == 24) begin
               m_hr = 0;
               m_dow = (m_dow == 7) ? 1 : m_dow + 1;
               m_dom++;
               if (m_dom > mdays(m_mon, m_yr, m_cen)) begin
                  m_dom = 1; m_mon++;
                  if (m_mon == 13) begin
                     m_mon = 1; m_yr++;
                     if (m_yr == 100) begin
                        m_yr = 0; m_cen = (m_cen + 1) % 100;
                     end
                  end
               end
            end
         end
      end
   endtask

   task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [3:0] a, logic [7:0] d);
      @(negedge clk);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(logic [3:0] a, output logic [7:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic load();
      wr(4'd8, {5'd0, m_h24, m_bin, 1'b0});
      for (int a = 0; a < 8; a++) wr(4'(a), expect_reg(a));
   endtask

   task automatic pulse_tick();
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic check_all(string tag);
      logic [7:0] d;
      for (int a = 0; a < 8; a++) begin
         rd(4'(a), d);
         check(tag, d, expect_reg(a));
      end
   endtask

   task automatic run_case(string tag);
      load();
      pulse_tick();
      repeat (BUSY) @(negedge clk);
      model_step();
      check_all(tag);
   endtask

   task automatic set_t(int h, int mi, int s, int dw, int dm, int mo, int y, int c);
      m_hr = h; m_min = mi; m_sec = s; m_dow = dw; m_dom = dm;
      m_mon = mo; m_yr = y; m_cen = c;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      int tmp;
      tmp = $urandom(32'd1234);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset values
      m_bin = 0; m_h24 = 1;
      set_t(0, 0, 0, 1, 1, 1, 0, 20);
      check_all("R1");
      rd(4'd8, d); check("R1 ctrl", d, 8'h04);
      rd(4'd9, d); check("R1 status", d, 8'h00);

      // R2 binary seconds/minutes wrap at 0x3B
      m_bin = 1; m_h24 = 1;
      set_t(0, 59, 59, 3, 10, 5, 40, 20); run_case("R2");
      m_bin = 0;
      set_t(5, 12, 59, 3, 10, 5, 40, 20); run_case("R2");

      // R3 24-hour wrap advances day
      m_bin = 0; m_h24 = 1;
      set_t(23, 59, 59, 2, 15, 6, 30, 20); run_case("R3");
      m_bin = 1;
      set_t(23, 59, 59, 2, 15, 6, 30, 20); run_case("R3");

      // R4 12-hour transitions
      m_h24 = 0; m_bin = 0;
      set_t(11, 59, 59, 4, 8, 3, 11, 20); run_case("R4");
      m_bin = 1;
      set_t(23, 59, 59, 4, 8, 3, 11, 20); run_case("R4");
      m_bin = 0;
      set_t(12, 59, 59, 4, 8, 3, 11, 20); run_case("R4");
      rd(4'd2, d); check("R4 pm one", d, 8'h81);

      // R5 month ends
      m_h24 = 1; m_bin = 0;
      set_t(23, 59, 59, 1, 30, 4, 12, 20); run_case("R5");
      set_t(23, 59, 59, 1, 31, 1, 12, 20); run_case("R5");
      set_t(23, 59, 59, 1, 30, 1, 12, 20); run_case("R5");

      // R6 leap years
      set_t(23, 59, 59, 1, 28, 2, 23, 20); run_case("R6");
      set_t(23, 59, 59, 1, 28, 2, 24, 20); run_case("R6");
      set_t(23, 59, 59, 1, 28, 2, 0, 20);  run_case("R6");
      set_t(23, 59, 59, 1, 28, 2, 0, 21);  run_case("R6");
      m_bin = 1;
      set_t(23, 59, 59, 1, 29, 2, 0, 24);  run_case("R6");

      // R7 year and century wrap
      m_bin = 0;
      set_t(23, 59, 59, 5, 31, 12, 99, 99); run_case("R7");

      // R8 day of week wrap
      set_t(23, 59, 59, 7, 3, 3, 50, 20); run_case("R8");

      // R9 window timing
      set_t(10, 20, 30, 2, 2, 2, 2, 20);
      load();
      pulse_tick();
      for (int k = 0; k < BUSY; k++) begin
         rd(4'd9, d); check("R9 busy high", d, 8'h01);
         @(negedge clk);
      end
      rd(4'd9, d); check("R9 busy low", d, 8'h00);
      model_step();
      rd(4'd0, d); check("R9 sec", d, expect_reg(0));

      // R9 tick ignored with divider off
      div_en = 1'b0;
      pulse_tick();
      rd(4'd9, d); check("R9 div off busy", d, 8'h00);
      repeat (BUSY) @(negedge clk);
      rd(4'd0, d); check("R9 div off sec", d, expect_reg(0));
      div_en = 1'b1;

      // R10 frozen ticks ignored
      wr(4'd8, {5'd0, m_h24, m_bin, 1'b1});
      pulse_tick();
      repeat (BUSY) @(negedge clk);
      rd(4'd9, d); check("R10 frozen busy", d, 8'h00);
      rd(4'd0, d); check("R10 frozen sec", d, expect_reg(0));
      rd(4'd8, d); check("R10 ctrl", d, {5'd0, m_h24, m_bin, 1'b1});
      wr(4'd8, {5'd0, m_h24, m_bin, 1'b0});

      // R10 abort inside window
      pulse_tick();
      wr(4'd8, {5'd0, m_h24, m_bin, 1'b1});
      rd(4'd9, d); check("R10 abort busy", d, 8'h00);
      repeat (BUSY) @(negedge clk);
      rd(4'd0, d); check("R10 abort sec", d, expect_reg(0));
      wr(4'd8, {5'd0, m_h24, m_bin, 1'b0});

      // R11 host blocked inside window
      pulse_tick();
      rd(4'd0, d); check("R11 read blank", d, 8'h00);
      wr(4'd0, 8'h44);
      repeat (BUSY) @(negedge clk);
      model_step();
      rd(4'd0, d); check("R11 write dropped", d, expect_reg(0));

      // R12 constrained random
      for (int it = 0; it < 60; it++) begin
         m_bin = 1'($urandom % 2);
         m_h24 = 1'($urandom % 2);
         m_sec = ($urandom % 2) ? 59 : int'($urandom % 60);
         m_min = ($urandom % 2) ? 59 : int'($urandom % 60);
         m_hr  = ($urandom % 3 == 0) ? 23 : int'($urandom % 24);
         m_mon = 1 + int'($urandom % 12);
         m_yr  = ($urandom % 4 == 0) ? 99 : int'($urandom % 100);
         m_cen = int'($urandom % 100);
         m_dow = 1 + int'($urandom % 7);
         m_dom = ($urandom % 2) ? mdays(m_mon, m_yr, m_cen)
                                : 1 + int'($urandom % 28);
         run_case("R12");
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule